// File: doc/BRIEF.md
# Prioritized Multi-Output Interrupt Controller

This block collects a set of interrupt request lines and steers them onto a smaller set of interrupt outputs. Each request line has its own enable, its own choice of level or edge detection, its own polarity, a priority value and a routing mask. The routing mask lets one request drive any number of the outputs. Every request line passes through a two-flop synchronizer before detection. Edge-mode requests are caught in a sticky pending bit. Level-mode requests count as pending only while the active level is present.

For each output, the block works out the winning request among the enabled pending requests routed to that output. It exposes the winner's priority value and request number in a register, so an interrupt handler can dispatch straight to the right service routine. Software reaches everything through an APB slave port with no wait states. It can also force pending bits on or off. The defaults are 32 requests, 8 outputs and 5-bit priorities.

Top module: `irq_router_apb`

## Requirements
- R1: After reset, every enable, edge-mode, polarity, priority and routing field reads 0, no request is pending, all outputs are low and every winner register reads 0.
- R2: Every APB access completes with `pready` high and `pslverr` low. A write takes effect at the clock edge that ends its access phase. The per-request configuration word at 0x100 + 4*n reads back as written: priority in bits [4:0], routing mask in bits [15:8]. Unmapped addresses read as 0 and ignore writes.
- R3: Request inputs are synchronized by two flops. A level-mode change that is present before clock edge k reaches the outputs after edge k+1. An edge-mode transition is latched at edge k+2.
- R4: Polarity register (0x008): bit n = 1 makes request n active low; bit n = 0 makes it active high.
- R5: Edge-mode register (0x004): bit n = 0 selects level mode. A level-mode request stops being pending as soon as its synchronized input returns to the inactive level.
- R6: With edge-mode bit n = 1, an inactive-to-active transition sets pending bit n. The bit stays set after the input returns inactive, until software clears it.
- R7: Writing 1s to 0x00C sets pending bits and writing 1s to 0x010 clears them; bits written as 0 leave pending bits alone. A hardware edge detected at the same clock edge as a clear of that bit leaves the bit set.
- R8: Enable register (0x000): a request whose enable bit is 0 drives no output and is never a winner, although its pending bit is still visible.
- R9: Output m is high exactly when at least one enabled pending request has routing-mask bit m set. Register 0x014 returns the outputs in bits [7:0].
- R10: The winner register for output m at 0x200 + 4*m holds the largest priority value among enabled pending requests routed to m in bits [4:0], a valid flag in bit 8 and the winning request number in bits [20:16]. It reads 0 when no such request exists.
- R11: When several candidates share the largest priority value, the lowest-numbered request wins.
- R12: Reading 0x00C or 0x010 returns the pending state of every request: the latched bit OR'ed with the current level-mode activity, whatever the enable bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock for the APB port and all state |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high: no wait states |
| pslverr | output | 1 | Always low: no error response |
| irq_req_i | input | 32 | Asynchronous interrupt request lines |
| irq_out_o | output | 8 | Interrupt outputs |

## Verification
Assertions check several properties on every cycle. A latched pending bit never drops unless it was cleared. A level-mode source never creates a latched bit by itself. Each output agrees with its resolver's valid flag. The reported winner is always enabled, pending and routed to that output, and no other candidate beats it on priority or on request number in a tie. Other behaviours can only be shown by the bench's scenarios: the two-flop latency, polarity inversion, the edge-beats-clear race, read-back of configuration, and the exact winner word under ties and priority changes. The bench scenarios run alongside a behavioural model compared on every clock.

// File: rtl/irq_router_pkg.sv
// Package: shared constants for the interrupt router.
// Holds default sizes, register page/slot numbers and the decoded register selector type.
package irq_router_pkg;

    localparam int unsigned DEF_SRC_N  = 32;
    localparam int unsigned DEF_OUT_N  = 8;
    localparam int unsigned DEF_PRIO_W = 5;
    localparam int unsigned DEF_ADDR_W = 12;

    // Address layout: paddr[ADDR_W-1:8] selects a page, paddr[7:2] a word slot.
    localparam int unsigned PAGE_CTRL = 0;
    localparam int unsigned PAGE_CFG  = 1;
    localparam int unsigned PAGE_WIN  = 2;

    localparam int unsigned SLOT_ENABLE = 0;
    localparam int unsigned SLOT_EDGE   = 1;
    localparam int unsigned SLOT_INVERT = 2;
    localparam int unsigned SLOT_SET    = 3;
    localparam int unsigned SLOT_CLR    = 4;
    localparam int unsigned SLOT_STAT   = 5;

    // Bit positions inside configuration and winner words.
    localparam int unsigned CFG_ROUTE_LSB = 8;
    localparam int unsigned WIN_VALID_BIT = 8;
    localparam int unsigned WIN_IDX_LSB   = 16;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_ENABLE,
        SEL_EDGE,
        SEL_INVERT,
        SEL_SET,
        SEL_CLR,
        SEL_STAT,
        SEL_CFG,
        SEL_WIN
    } reg_sel_e;

endpackage

// File: rtl/irq_router_regs.sv
// Module: APB register file of the interrupt router.
// Decodes the address, holds per-request configuration, and produces one-cycle
// set/clear strobes for the pending latches. Read data is combinational.
// Assumes SRC_N <= 32, SRC_N <= 64 slots, OUT_N <= 8, PRIO_W <= 8, ADDR_W >= 10.
module irq_router_regs
    import irq_router_pkg::*;
#(
    parameter int unsigned SRC_N  = DEF_SRC_N,
    parameter int unsigned OUT_N  = DEF_OUT_N,
    parameter int unsigned PRIO_W = DEF_PRIO_W,
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned IDX_W  = $clog2(SRC_N)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          psel_i,
    input  logic                          penable_i,
    input  logic                          pwrite_i,
    input  logic [ADDR_W-1:0]             paddr_i,
    input  logic [31:0]                   pwdata_i,
    output logic [31:0]                   prdata_o,
    input  logic [SRC_N-1:0]              pend_i,
    input  logic [OUT_N-1:0]              out_i,
    input  logic [OUT_N-1:0]              win_valid_i,
    input  logic [OUT_N-1:0][IDX_W-1:0]   win_idx_i,
    input  logic [OUT_N-1:0][PRIO_W-1:0]  win_lvl_i,
    output logic [SRC_N-1:0]              enable_o,
    output logic [SRC_N-1:0]              edge_o,
    output logic [SRC_N-1:0]              invert_o,
    output logic [SRC_N-1:0][PRIO_W-1:0]  prio_o,
    output logic [SRC_N-1:0][OUT_N-1:0]   route_o,
    output logic [SRC_N-1:0]              set_o,
    output logic [SRC_N-1:0]              clr_o
);

    localparam int unsigned PAGE_W = ADDR_W - 8;
    localparam int unsigned SLOT_W = 6;
    localparam int unsigned OUT_W  = (OUT_N > 1) ? $clog2(OUT_N) : 1;

    logic [PAGE_W-1:0] page;
    logic [SLOT_W-1:0] slot;
    logic              aligned;
    logic              wr_en;
    reg_sel_e          sel;
    logic [IDX_W-1:0]  src_sel;
    logic [OUT_W-1:0]  out_sel;

    assign page    = paddr_i[ADDR_W-1:8];
    assign slot    = paddr_i[7:2];
    assign aligned = (paddr_i[1:0] == 2'b00);
    assign wr_en   = psel_i && penable_i && pwrite_i;
    assign src_sel = slot[IDX_W-1:0];
    assign out_sel = slot[OUT_W-1:0];

    // Address decode: map page/slot to a register selector.
    always_comb begin
        sel = SEL_NONE;
        if (aligned) begin
            if (page == PAGE_W'(PAGE_CTRL)) begin
                case (32'(slot))
                    SLOT_ENABLE: sel = SEL_ENABLE;
                    SLOT_EDGE:   sel = SEL_EDGE;
                    SLOT_INVERT: sel = SEL_INVERT;
                    SLOT_SET:    sel = SEL_SET;
                    SLOT_CLR:    sel = SEL_CLR;
                    SLOT_STAT:   sel = SEL_STAT;
                    default:     sel = SEL_NONE;
                endcase
            end else if (page == PAGE_W'(PAGE_CFG) && 32'(slot) < SRC_N) begin
                sel = SEL_CFG;
            end else if (page == PAGE_W'(PAGE_WIN) && 32'(slot) < OUT_N) begin
                sel = SEL_WIN;
            end
        end
    end

    // Configuration storage: updated at the end of an APB write access phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_o <= '0;
            edge_o   <= '0;
            invert_o <= '0;
            prio_o   <= '0;
            route_o  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_ENABLE: enable_o <= pwdata_i[SRC_N-1:0];
                SEL_EDGE:   edge_o   <= pwdata_i[SRC_N-1:0];
                SEL_INVERT: invert_o <= pwdata_i[SRC_N-1:0];
                SEL_CFG: begin
                    prio_o[src_sel]  <= pwdata_i[PRIO_W-1:0];
                    route_o[src_sel] <= pwdata_i[CFG_ROUTE_LSB +: OUT_N];
                end
                default: ;
            endcase
        end
    end

    // Write-one strobes for the pending latches, valid only in the commit cycle.
    assign set_o = (wr_en && sel == SEL_SET) ? pwdata_i[SRC_N-1:0] : '0;
    assign clr_o = (wr_en && sel == SEL_CLR) ? pwdata_i[SRC_N-1:0] : '0;

    // Read mux: return the selected register during a read access.
    always_comb begin
        prdata_o = '0;
        if (psel_i && !pwrite_i) begin
            case (sel)
                SEL_ENABLE: prdata_o[SRC_N-1:0] = enable_o;
                SEL_EDGE:   prdata_o[SRC_N-1:0] = edge_o;
                SEL_INVERT: prdata_o[SRC_N-1:0] = invert_o;
                SEL_SET,
                SEL_CLR:    prdata_o[SRC_N-1:0] = pend_i;
                SEL_STAT:   prdata_o[OUT_N-1:0] = out_i;
                SEL_CFG: begin
                    prdata_o[PRIO_W-1:0]             = prio_o[src_sel];
                    prdata_o[CFG_ROUTE_LSB +: OUT_N] = route_o[src_sel];
                end
                SEL_WIN: begin
                    prdata_o[PRIO_W-1:0]           = win_lvl_i[out_sel];
                    prdata_o[WIN_VALID_BIT]        = win_valid_i[out_sel];
                    prdata_o[WIN_IDX_LSB +: IDX_W] = win_idx_i[out_sel];
                end
                default: prdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_src_capture.sv
// Module: request front end.
// Synchronizes each request line with two flops, applies polarity, detects
// inactive-to-active transitions and holds the sticky pending latches.
// Assumes set/clear strobes last exactly one cycle per APB write.
module irq_src_capture #(
    parameter int unsigned SRC_N = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] req_i,
    input  logic [SRC_N-1:0] edge_mode_i,
    input  logic [SRC_N-1:0] invert_i,
    input  logic [SRC_N-1:0] set_i,
    input  logic [SRC_N-1:0] clr_i,
    output logic [SRC_N-1:0] pend_o
);

    logic [SRC_N-1:0] sync1_q;
    logic [SRC_N-1:0] sync2_q;
    logic [SRC_N-1:0] act_prev_q;
    logic [SRC_N-1:0] latch_q;
    logic [SRC_N-1:0] act;
    logic [SRC_N-1:0] edge_hit;

    assign act      = sync2_q ^ invert_i;
    assign edge_hit = edge_mode_i & act & ~act_prev_q;

    // Two-flop synchronizer and previous-activity register for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q    <= '0;
            sync2_q    <= '0;
            act_prev_q <= '0;
        end else begin
            sync1_q    <= req_i;
            sync2_q    <= sync1_q;
            act_prev_q <= act;
        end
    end

    // Sticky pending latch: a hardware edge or a software set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            latch_q <= edge_hit | set_i | (latch_q & ~clr_i);
        end
    end

    assign pend_o = latch_q | (~edge_mode_i & act);

    // A latched bit only falls after a clear strobe.
    p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(latch_q) & ~$past(clr_i)) & ~latch_q) == '0));

    // A level-mode source never creates a latched bit without a software set.
    p_level_no_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((latch_q & ~$past(latch_q) & ~$past(set_i) & ~$past(edge_mode_i)) == '0));

endmodule

// File: rtl/irq_prio_pick.sv
// Module: priority resolver for one output.
// Scans the candidate vector and selects the largest priority value; on a tie the
// lowest request number is kept. Purely combinational; clk/rst_n serve the checks.
module irq_prio_pick #(
    parameter int unsigned SRC_N  = 32,
    parameter int unsigned PRIO_W = 5,
    parameter int unsigned IDX_W  = $clog2(SRC_N)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SRC_N-1:0]             cand_i,
    input  logic [SRC_N-1:0][PRIO_W-1:0] prio_i,
    output logic                         valid_o,
    output logic [IDX_W-1:0]             idx_o,
    output logic [PRIO_W-1:0]            level_o
);

    // Linear scan: a later candidate replaces the best only with a strictly larger value.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        level_o = '0;
        for (int i = 0; i < SRC_N; i++) begin
            if (cand_i[i] && (!valid_o || prio_i[i] > level_o)) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
                level_o = prio_i[i];
            end
        end
    end

    for (genvar j = 0; j < SRC_N; j++) begin : g_chk
        // No candidate beats the winner on value, nor ties it with a lower number.
        p_best_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_o && cand_i[j]) |->
                ((prio_i[j] < level_o) || (prio_i[j] == level_o && idx_o <= IDX_W'(j))));
    end

endmodule

// File: rtl/irq_router_apb.sv
// Module: top of the prioritized multi-output interrupt router.
// Connects the APB register file, the request front end and one priority
// resolver per output. APB accesses take no wait states and never error.
module irq_router_apb
    import irq_router_pkg::*;
#(
    parameter int unsigned SRC_N  = DEF_SRC_N,
    parameter int unsigned OUT_N  = DEF_OUT_N,
    parameter int unsigned PRIO_W = DEF_PRIO_W,
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic [SRC_N-1:0]  irq_req_i,
    output logic [OUT_N-1:0]  irq_out_o
);

    localparam int unsigned IDX_W = $clog2(SRC_N);

    logic [SRC_N-1:0]              enable_w;
    logic [SRC_N-1:0]              edge_w;
    logic [SRC_N-1:0]              invert_w;
    logic [SRC_N-1:0]              set_w;
    logic [SRC_N-1:0]              clr_w;
    logic [SRC_N-1:0]              pend_w;
    logic [SRC_N-1:0]              active_w;
    logic [SRC_N-1:0][PRIO_W-1:0]  prio_w;
    logic [SRC_N-1:0][OUT_N-1:0]   route_w;
    logic [OUT_N-1:0]              win_valid_w;
    logic [OUT_N-1:0][IDX_W-1:0]   win_idx_w;
    logic [OUT_N-1:0][PRIO_W-1:0]  win_lvl_w;
    logic [OUT_N-1:0][SRC_N-1:0]   cand_w;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    irq_router_regs #(
        .SRC_N  (SRC_N),
        .OUT_N  (OUT_N),
        .PRIO_W (PRIO_W),
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_regs (
        .clk         (pclk),
        .rst_n       (presetn),
        .psel_i      (psel),
        .penable_i   (penable),
        .pwrite_i    (pwrite),
        .paddr_i     (paddr),
        .pwdata_i    (pwdata),
        .prdata_o    (prdata),
        .pend_i      (pend_w),
        .out_i       (irq_out_o),
        .win_valid_i (win_valid_w),
        .win_idx_i   (win_idx_w),
        .win_lvl_i   (win_lvl_w),
        .enable_o    (enable_w),
        .edge_o      (edge_w),
        .invert_o    (invert_w),
        .prio_o      (prio_w),
        .route_o     (route_w),
        .set_o       (set_w),
        .clr_o       (clr_w)
    );

    irq_src_capture #(
        .SRC_N (SRC_N)
    ) u_capture (
        .clk         (pclk),
        .rst_n       (presetn),
        .req_i       (irq_req_i),
        .edge_mode_i (edge_w),
        .invert_i    (invert_w),
        .set_i       (set_w),
        .clr_i       (clr_w),
        .pend_o      (pend_w)
    );

    assign active_w = pend_w & enable_w;

    for (genvar o = 0; o < OUT_N; o++) begin : g_out
        for (genvar i = 0; i < SRC_N; i++) begin : g_src
            assign cand_w[o][i] = active_w[i] & route_w[i][o];
        end

        irq_prio_pick #(
            .SRC_N  (SRC_N),
            .PRIO_W (PRIO_W),
            .IDX_W  (IDX_W)
        ) u_pick (
            .clk     (pclk),
            .rst_n   (presetn),
            .cand_i  (cand_w[o]),
            .prio_i  (prio_w),
            .valid_o (win_valid_w[o]),
            .idx_o   (win_idx_w[o]),
            .level_o (win_lvl_w[o])
        );

        assign irq_out_o[o] = |cand_w[o];

        // Output line and resolver valid flag come from separate logic and must agree.
        p_out_valid_r9: assert property (@(posedge pclk) disable iff (!presetn)
            irq_out_o[o] == win_valid_w[o]);

        // A reported winner is enabled, pending and routed to this output.
        p_win_routed_r10: assert property (@(posedge pclk) disable iff (!presetn)
            win_valid_w[o] |-> (route_w[win_idx_w[o]][o] && active_w[win_idx_w[o]]));
    end

endmodule

// File: tb/irq_router_apb_test.sv
// Bench: drives APB and request lines, keeps a behavioural model updated at each
// rising edge and compares outputs on every falling edge, plus named scenario checks.
module irq_router_apb_test;

    localparam int SN = 32;
    localparam int ON = 8;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] req = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;
    logic [7:0]  irq_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    irq_router_apb uut (
        .pclk      (pclk),
        .presetn   (presetn),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .prdata    (prdata),
        .pready    (pready),
        .pslverr   (pslverr),
        .irq_req_i (req),
        .irq_out_o (irq_out)
    );

    always #2 pclk = ~pclk;

    // Behavioural model state.
    logic [31:0] m_s1, m_s2, m_prev, m_latch, m_en, m_edge, m_inv;
    int          m_prio [SN];
    logic [7:0]  m_route [SN];

    function automatic logic [31:0] m_pend();
        return m_latch | (~m_edge & (m_s2 ^ m_inv));
    endfunction

    function automatic logic [7:0] m_out();
        logic [31:0] act;
        logic [7:0]  r;
        act = m_pend() & m_en;
        r = '0;
        for (int i = 0; i < SN; i++)
            if (act[i]) r = r | m_route[i];
        return r;
    endfunction

    function automatic logic [31:0] m_win(int o);
        logic [31:0] act;
        int best;
        int idx;
        act = m_pend() & m_en;
        best = -1;
        idx = 0;
        for (int i = 0; i < SN; i++)
            if (act[i] && m_route[i][o] && m_prio[i] > best) begin
                best = m_prio[i];
                idx = i;
            end
        if (best < 0) return 32'h0;
        return (32'(idx) << 16) | 32'h100 | 32'(best);
    endfunction

    function automatic logic [31:0] m_read(logic [11:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        if (a == 12'h000) return m_en;
        if (a == 12'h004) return m_edge;
        if (a == 12'h008) return m_inv;
        if (a == 12'h00C || a == 12'h010) return m_pend();
        if (a == 12'h014) return {24'h0, m_out()};
        if (a >= 12'h100 && a < 12'h180)
            return {16'h0, m_route[(a - 12'h100) >> 2], 3'b000, 5'(m_prio[(a - 12'h100) >> 2])};
        if (a >= 12'h200 && a < 12'h220) return m_win(int'((a - 12'h200) >> 2));
        return 32'h0;
    endfunction

    // Advance the model by one rising edge using the inputs held across it.
    task automatic model_update();
        logic [31:0] a, e, setm, clrm;
        bit wr;
        if (!presetn) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_latch = '0;
            m_en = '0; m_edge = '0; m_inv = '0;
            for (int i = 0; i < SN; i++) begin
                m_prio[i] = 0;
                m_route[i] = '0;
            end
        end else begin
            wr = psel && penable && pwrite;
            a = m_s2 ^ m_inv;
            e = m_edge & a & ~m_prev;
            setm = (wr && paddr == 12'h00C) ? pwdata : 32'h0;
            clrm = (wr && paddr == 12'h010) ? pwdata : 32'h0;
            m_latch = e | setm | (m_latch & ~clrm);
            m_prev = a;
            m_s2 = m_s1;
            m_s1 = req;
            if (wr) begin
                if (paddr == 12'h000) m_en = pwdata;
                if (paddr == 12'h004) m_edge = pwdata;
                if (paddr == 12'h008) m_inv = pwdata;
                if (paddr >= 12'h100 && paddr < 12'h180 && paddr[1:0] == 2'b00) begin
                    m_prio[(paddr - 12'h100) >> 2] = int'(pwdata[4:0]);
                    m_route[(paddr - 12'h100) >> 2] = pwdata[15:8];
                end
            end
        end
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: model at the rising edge, comparison at the falling edge.
    task automatic step();
        @(posedge pclk);
        model_update();
        @(negedge pclk);
        check("R9 model", {24'h0, irq_out}, {24'h0, m_out()});
        check("R2 handshake", {30'h0, pready, pslverr}, 32'h2);
    endtask

    task automatic steps(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic apb_write(logic [11:0] a, logic [31:0] d);
        paddr = a; pwdata = d; pwrite = 1'b1; psel = 1'b1; penable = 1'b0;
        step();
        penable = 1'b1;
        step();
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(logic [11:0] a, output logic [31:0] d);
        paddr = a; pwrite = 1'b0; psel = 1'b1; penable = 1'b0;
        step();
        penable = 1'b1;
        #1;
        d = prdata;
        check("R12 model read", d, m_read(a));
        step();
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge pclk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        @(negedge pclk);
        steps(3);
        presetn = 1'b1;
        step();

        // R1: reset state
        check("R1 outputs", {24'h0, irq_out}, 32'h0);
        apb_read(12'h000, d); check("R1 enable", d, 32'h0);
        apb_read(12'h00C, d); check("R1 pending", d, 32'h0);
        apb_read(12'h104, d); check("R1 config", d, 32'h0);
        apb_read(12'h200, d); check("R1 winner", d, 32'h0);

        // R2: configuration read-back and unmapped addresses
        apb_write(12'h10C, 32'h0000_0107);
        apb_read(12'h10C, d); check("R2 cfg3", d, 32'h0000_0107);
        apb_write(12'h17C, 32'h0000_FF1F);
        apb_read(12'h17C, d); check("R2 cfg31", d, 32'h0000_FF1F);
        apb_write(12'h050, 32'hFFFF_FFFF);
        apb_read(12'h050, d); check("R2 unmapped", d, 32'h0);
        apb_write(12'h000, 32'hFFFF_FFFF);

        // R3: level request latency, R10 winner word
        req[3] = 1'b1;
        step(); check("R3 not yet", {31'h0, irq_out[0]}, 32'h0);
        step(); check("R3 arrives", {31'h0, irq_out[0]}, 32'h1);
        apb_read(12'h200, d); check("R10 winner out0", d, 32'h0003_0107);

        // R5: level mode is not latched
        req[3] = 1'b0;
        steps(2);
        check("R5 drops", {31'h0, irq_out[0]}, 32'h0);
        apb_read(12'h00C, d); check("R5 no latch", d, 32'h0);

        // R4: polarity
        apb_write(12'h110, 32'h0000_0202);
        apb_write(12'h008, 32'h0000_0010);
        check("R4 active low idle", {31'h0, irq_out[1]}, 32'h1);
        req[4] = 1'b1;
        steps(2);
        check("R4 active low driven", {31'h0, irq_out[1]}, 32'h0);
        req[4] = 1'b0;
        steps(2);
        apb_write(12'h008, 32'h0);
        check("R4 restored", {24'h0, irq_out}, 32'h0);

        // R6: edge mode latches
        apb_write(12'h114, 32'h0000_0404);
        apb_write(12'h004, 32'h0000_0020);
        req[5] = 1'b1;
        step();
        req[5] = 1'b0;
        step(); check("R3 edge latency", {31'h0, irq_out[2]}, 32'h0);
        step(); check("R6 latched", {31'h0, irq_out[2]}, 32'h1);
        steps(4);
        check("R6 held", {31'h0, irq_out[2]}, 32'h1);
        apb_read(12'h010, d); check("R6 pending", d, 32'h0000_0020);

        // R7: clear with zeros then with a one
        apb_write(12'h010, 32'h0);
        check("R7 zero clear", {31'h0, irq_out[2]}, 32'h1);
        apb_write(12'h010, 32'h0000_0020);
        check("R7 clear", {31'h0, irq_out[2]}, 32'h0);

        // R8: disabled source stays pending but silent
        apb_write(12'h118, 32'h0000_0801);
        apb_write(12'h000, 32'hFFFF_FFBF);
        apb_write(12'h00C, 32'h0000_0040);
        apb_read(12'h00C, d); check("R12 pending disabled", d, 32'h0000_0040);
        check("R8 silent", {31'h0, irq_out[3]}, 32'h0);
        apb_read(12'h20C, d); check("R8 no winner", d, 32'h0);
        apb_write(12'h000, 32'hFFFF_FFFF);
        check("R8 enabled", {31'h0, irq_out[3]}, 32'h1);
        apb_write(12'h010, 32'h0000_0040);

        // R9: one request to several outputs
        apb_write(12'h11C, 32'h0000_A109);
        apb_write(12'h00C, 32'h0000_0080);
        check("R9 fan-out", {24'h0, irq_out}, 32'h0000_00A1);
        apb_read(12'h014, d); check("R9 status", d, 32'h0000_00A1);
        apb_read(12'h21C, d); check("R10 winner out7", d, 32'h0007_0109);

        // R11: tie goes to the lower number
        apb_write(12'h010, 32'h0000_0080);
        apb_write(12'h124, 32'h0000_8009);
        apb_write(12'h130, 32'h0000_8009);
        apb_write(12'h00C, 32'h0000_1200);
        apb_read(12'h21C, d); check("R11 tie", d, 32'h0009_0109);
        apb_write(12'h130, 32'h0000_800A);
        apb_read(12'h21C, d); check("R10 higher wins", d, 32'h000C_010A);
        apb_write(12'h00C, 32'h8000_0000);
        apb_read(12'h218, d); check("R10 top priority", d, 32'h001F_011F);

        // R7: hardware edge beats a simultaneous clear
        apb_write(12'h128, 32'h0000_1003);
        apb_write(12'h004, 32'h0000_0420);
        req[10] = 1'b1;
        step();
        apb_write(12'h010, 32'h0000_0400);
        apb_read(12'h00C, d); check("R7 edge wins", d, 32'h8000_1600);
        check("R7 edge out", {31'h0, irq_out[4]}, 32'h1);

        steps(4);
        finish_run();
    end

endmodule